// File: doc/BRIEF.md
# PWM Period Timebase with Debug Drain

This block is the period counter that sits under a PWM generator. It holds a 16-bit count and runs it in one of two shapes: a falling sawtooth or a rising-then-falling triangle. The turning value comes from a period input that a register stage elsewhere keeps stable. The block emits two single-cycle events: one when the count sits at zero and one when it sits at the period value. It also emits a direction flag that a downstream comparator uses to tell the rising half of a triangle from the falling half.

A small control state machine decides whether the count advances in a given cycle. It has four states:

- `ST_OFF`: disabled. The count is frozen, not zeroed.
- `ST_RUN`: counting freely.
- `ST_DRAIN`: a system debug halt has been requested. The counter keeps running until it reaches zero.
- `ST_HALT`: parked at zero until the halt request drops.

The transitions are named as follows:

- `T_ENABLE`: `ST_OFF` to `ST_RUN` when enable is high.
- `T_DISABLE`: any state to `ST_OFF` when enable is low.
- `T_HALT_REQ`: `ST_RUN` to `ST_DRAIN` when a halt request is seen.
- `T_PARK`: `ST_DRAIN` to `ST_HALT` when the count is zero.
- `T_CANCEL`: `ST_DRAIN` to `ST_RUN` when the request drops.
- `T_RESUME`: `ST_HALT` to `ST_RUN` when the request drops.

A halt request is the debug-halt input while the free-run-in-debug bit is low. A separate synchronous clear is the only way to zero the count.

Top module: `pwm_timebase`

## Requirements
- R1: With `mode`=0 and the state machine in `ST_RUN`, each cycle the count drops by one, and from 0 it loads `period` (period 3 gives 0,3,2,1,0,3).
- R2: With `mode`=1 the count climbs from 0 to `period` and then falls back to 0, repeating (period 3 gives 0,1,2,3,2,1,0,1).
- R3: While `dbg_halt`=1 and `dbg_freerun`=0, the count keeps advancing until it reads 0. It then holds 0 with no events. After `dbg_halt` drops, the count is still 0 for one cycle with a zero event, and then advances again.
- R4: With `dbg_freerun`=1, `dbg_halt` has no effect and the counter keeps advancing.
- R5: While `en`=0 the count holds its value and neither event fires. Raising `en` again continues from the held value.
- R6: After reset the count is 0 and `dir_up` is 0. In the first cycle after `en` rises the count does not advance and no event fires.
- R7: `clr`=1 sets the count to 0 at the next edge whatever `en` is, and sets `dir_up` to the value of `mode`.
- R8: `zero_evt` is 1 exactly in cycles where the count advances from 0. `period_evt` is 1 exactly in cycles where the count advances from a value equal to `period`.
- R9: In mode 1, `dir_up` is 1 while the count is rising and 0 while it is falling. It turns to 1 after an advance from 0 and to 0 after an advance from `period`. In mode 0 it is 0.
- R10: A `period` of 0 keeps the count at 0 in both modes, with both events firing in every advancing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Counter enable; low freezes the count |
| mode | input | 1 | 0 = falling sawtooth, 1 = triangle |
| dbg_freerun | input | 1 | 1 = ignore the debug halt |
| dbg_halt | input | 1 | System debug halt request |
| period | input | 16 | Turning value of the count |
| clr | input | 1 | Synchronous count clear |
| count | output | 16 | Current count |
| zero_evt | output | 1 | Advance from zero this cycle |
| period_evt | output | 1 | Advance from the period value this cycle |
| dir_up | output | 1 | 1 while counting up in triangle mode |

## Verification
A control state stuck in `ST_DRAIN` or `ST_HALT` shows within one cycle: the count parks at 0 and `zero_evt` stays silent. A state that fails to leave `ST_OFF` gives a count that never moves even though `en` is high. A corrupted direction bit surfaces at the next advance as a count stepping the wrong way, or as a triangle that passes through `period`. A wrong reload value appears one cycle after the count reaches zero. The directed sequences compare every cycle, so each of these faults is caught at the first cycle it becomes visible.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HALT  = 2'd3
    } tb_state_t;
endpackage

// File: rtl/pwm_tb_ctrl.sv
module pwm_tb_ctrl
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            halt_req,
    input  logic [CW-1:0]   cnt,
    output tb_state_t       state,
    output logic            adv
);
    tb_state_t state_q, state_d;
    logic      at_zero;

    assign at_zero = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;                       // T_DISABLE
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_RUN;         // T_ENABLE
                ST_RUN:   if (halt_req) state_d = ST_DRAIN;  // T_HALT_REQ
                ST_DRAIN: begin
                    if (!halt_req)    state_d = ST_RUN;      // T_CANCEL
                    else if (at_zero) state_d = ST_HALT;     // T_PARK
                end
                ST_HALT:  if (!halt_req) state_d = ST_RUN;   // T_RESUME
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        adv = 1'b0;
        unique case (state_q)
            ST_RUN:   adv = en;
            ST_DRAIN: adv = en && !at_zero;
            default:  adv = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pwm_tb_step.sv
module pwm_tb_step #(
    parameter int CW = 16
) (
    input  logic          tri_mode,
    input  logic          up_q,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] cnt_nxt,
    output logic          up_nxt
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic at_zero, at_top;

    assign at_zero = (cnt == '0);
    assign at_top  = (cnt >= per);

    always_comb begin
        if (!tri_mode) begin
            up_nxt  = 1'b0;
            cnt_nxt = at_zero ? per : cnt - ONE;
        end else begin
            if (at_zero)     up_nxt = 1'b1;
            else if (at_top) up_nxt = 1'b0;
            else             up_nxt = up_q;
            if (per == '0)   cnt_nxt = '0;
            else if (up_nxt) cnt_nxt = cnt + ONE;
            else             cnt_nxt = cnt - ONE;
        end
    end
endmodule

// File: rtl/pwm_tb_events.sv
module pwm_tb_events #(
    parameter int CW = 16
) (
    input  logic          adv,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per,
    output logic          zero_evt,
    output logic          period_evt
);
    assign zero_evt   = adv && (cnt == '0);
    assign period_evt = adv && (cnt == per);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          mode,
    input  logic          dbg_freerun,
    input  logic          dbg_halt,
    input  logic [CW-1:0] period,
    input  logic          clr,
    output logic [CW-1:0] count,
    output logic          zero_evt,
    output logic          period_evt,
    output logic          dir_up
);
    tb_state_t     state;
    logic          adv, halt_req, up_nxt, up_q;
    logic [CW-1:0] cnt_q, cnt_nxt;

    assign halt_req = dbg_halt && !dbg_freerun;

    pwm_tb_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .halt_req(halt_req),
        .cnt(cnt_q), .state(state), .adv(adv)
    );

    pwm_tb_step #(.CW(CW)) u_step (
        .tri_mode(mode), .up_q(up_q), .cnt(cnt_q), .per(period),
        .cnt_nxt(cnt_nxt), .up_nxt(up_nxt)
    );

    pwm_tb_events #(.CW(CW)) u_evt (
        .adv(adv), .cnt(cnt_q), .per(period),
        .zero_evt(zero_evt), .period_evt(period_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b0;
        end else if (clr) begin
            cnt_q <= '0;
            up_q  <= mode;
        end else if (adv) begin
            cnt_q <= cnt_nxt;
            up_q  <= up_nxt;
        end
    end

    assign count  = cnt_q;
    assign dir_up = up_q;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          mode,
    input logic          dbg_freerun,
    input logic          clr,
    input logic [CW-1:0] count,
    input logic          zero_evt,
    input logic          dir_up,
    input tb_state_t     state
);
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && !mode && !clr && count != '0) |=> count == $past(count) - CW'(1)); // R1
    AST_HALT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |-> (count == '0 && !zero_evt)); // R3
    AST_FREERUN_NO_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_freerun && en) |=> state == ST_RUN); // R4
    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(count)); // R5
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == '0); // R7
    AST_TURN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en && mode && !clr && count == '0) |=> dir_up); // R9
endmodule

bind pwm_timebase pwm_timebase_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .dbg_freerun(dbg_freerun),
    .clr(clr), .count(count), .zero_evt(zero_evt), .dir_up(dir_up), .state(state)
);

// File: tb/pwm_timebase_tb.sv
`timescale 1ns/1ps
module pwm_timebase_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, mode = 1'b0, dbg_freerun = 1'b0, dbg_halt = 1'b0, clr = 1'b0;
    logic [15:0] period = 16'd0;
    logic [15:0] count;
    logic        zero_evt, period_evt, dir_up;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    pwm_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .dbg_freerun(dbg_freerun),
        .dbg_halt(dbg_halt), .period(period), .clr(clr), .count(count),
        .zero_evt(zero_evt), .period_evt(period_evt), .dir_up(dir_up)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string req, input logic [15:0] c, input logic d,
                              input logic z, input logic p);
        checks++;
        if (count !== c || dir_up !== d || zero_evt !== z || period_evt !== p) begin
            errors++;
            $display("FAIL %s: count=%0d dir=%b zero=%b per=%b, expected count=%0d dir=%b zero=%b per=%b",
                     req, count, dir_up, zero_evt, period_evt, c, d, z, p);
        end
    endtask

    task automatic prep(input logic m, input logic [15:0] per);
        en = 1'b0; clr = 1'b1; mode = m; period = per;
        step();
        clr = 1'b0; en = 1'b1;
        step();
    endtask

    task automatic t_reset();
        expect_out("R6 reset", 16'd0, 1'b0, 1'b0, 1'b0);
        mode = 1'b0; period = 16'd3; en = 1'b1;
        expect_out("R6 first enabled cycle", 16'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_down();
        step(); expect_out("R1 R8 zero", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R1 R8 reload", 16'd3, 1'b0, 1'b0, 1'b1);
        step(); expect_out("R1", 16'd2, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R1", 16'd1, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R1", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R1 wrap", 16'd3, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_updown();
        prep(1'b1, 16'd3);
        expect_out("R2 R7 R9 start", 16'd0, 1'b1, 1'b1, 1'b0);
        step(); expect_out("R2 R9", 16'd1, 1'b1, 1'b0, 1'b0);
        step(); expect_out("R2 R9", 16'd2, 1'b1, 1'b0, 1'b0);
        step(); expect_out("R2 R8 top", 16'd3, 1'b1, 1'b0, 1'b1);
        step(); expect_out("R2 R9 turn down", 16'd2, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R2 R9", 16'd1, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R2 R8 bottom", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R2 R9 turn up", 16'd1, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_halt();
        prep(1'b0, 16'd4);
        dbg_halt = 1'b1; dbg_freerun = 1'b0;
        expect_out("R3 request seen", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R3 drain", 16'd4, 1'b0, 1'b0, 1'b1);
        step(); expect_out("R3 drain", 16'd3, 1'b0, 1'b0, 1'b0);
        step(); step();
        expect_out("R3 drain", 16'd1, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R3 reach zero", 16'd0, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R3 parked", 16'd0, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R3 parked", 16'd0, 1'b0, 1'b0, 1'b0);
        dbg_halt = 1'b0;
        expect_out("R3 release", 16'd0, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R3 resumed", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R3 running", 16'd4, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_freerun();
        prep(1'b0, 16'd2);
        dbg_halt = 1'b1; dbg_freerun = 1'b1;
        expect_out("R4", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R4", 16'd2, 1'b0, 1'b0, 1'b1);
        step(); expect_out("R4", 16'd1, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R4 passes zero", 16'd0, 1'b0, 1'b1, 1'b0);
        step(); expect_out("R4 keeps going", 16'd2, 1'b0, 1'b0, 1'b1);
        dbg_halt = 1'b0; dbg_freerun = 1'b0;
    endtask

    task automatic t_disable();
        prep(1'b0, 16'd5);
        step(); step();
        expect_out("R5 pre", 16'd4, 1'b0, 1'b0, 1'b0);
        en = 1'b0;
        expect_out("R5 off now", 16'd4, 1'b0, 1'b0, 1'b0);
        step(); step();
        expect_out("R5 frozen", 16'd4, 1'b0, 1'b0, 1'b0);
        en = 1'b1;
        step(); expect_out("R5 R6 restart latency", 16'd4, 1'b0, 1'b0, 1'b0);
        step(); expect_out("R5 continues", 16'd3, 1'b0, 1'b0, 1'b0);
        en = 1'b0; clr = 1'b1; mode = 1'b1;
        step(); clr = 1'b0;
        expect_out("R7 clear while off", 16'd0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_zero_period();
        prep(1'b0, 16'd0);
        expect_out("R10 down", 16'd0, 1'b0, 1'b1, 1'b1);
        step(); expect_out("R10 down", 16'd0, 1'b0, 1'b1, 1'b1);
        prep(1'b1, 16'd0);
        step(); expect_out("R10 tri", 16'd0, 1'b1, 1'b1, 1'b1);
        step(); expect_out("R10 tri", 16'd0, 1'b1, 1'b1, 1'b1);
    endtask

    initial begin
        fork
            begin
                #3; step(); step();
                rst_n = 1'b1;
                #1;
                t_reset();
                t_down();
                t_updown();
                t_halt();
                t_freerun();
                t_disable();
                t_zero_period();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule